// File: doc/BRIEF.md
# Software Interrupt Fan-Out Unit

This block turns one 32-bit command word, written by a CPU into the software-interrupt register, into interrupt state for a group of CPUs. The word carries an interrupt number from 0 to 15, an explicit list of target CPUs and a two-bit filter. The filter chooses how the targets are picked: from the explicit list, as every online CPU except the one writing, or as the writer alone. For each chosen CPU the block sets the pending bit of that interrupt number. It also records the writer's id in a source mask that is kept for each pair of target CPU and interrupt number.

The writer supplies its own id, and the system supplies the number of CPUs currently online (numbered from zero upward). The pending bits and the source masks stay set until reset. A downstream delivery and acknowledge path, which is outside this block, consumes them. A one-cycle completion pulse and a one-cycle mask of the CPUs hit let neighbouring logic follow each command. Reading the register always gives zero.

Top module: `sgid_dispatch`

## Requirements
- R1: The fields are decoded from fixed positions: interrupt number from bits [3:0], target list from bits [23:16] (bit 16 is CPU 0), filter from bits [25:24]. All other bits of the word have no effect.
- R2: With filter 0, the targets are the list bits of CPUs that are online, meaning CPU ids below the online count. A list with no online CPU in it sets nothing.
- R3: With filter 1, the targets are all online CPUs except the requester.
- R4: With filter 2, the only target is the requester.
- R5: With filter 3, which is reserved, no CPU is targeted and no state changes.
- R6: For each target, the pending bit at index (target, interrupt number) is set, and no other pending bit changes. Pending bits are cleared only by reset.
- R7: For each target, bit (requester id) of the source mask at (target, interrupt number) is set, and no other source bit changes.
- R8: In the cycle after a write strobe, the state updates are visible, `done` is high and `hit` holds the target mask. In every other cycle `done` is low and `hit` is zero.
- R9: `rd_data` is always zero.
- R10: Reset clears all pending bits, source masks, `done` and `hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word |
| req_id | input | CPU_W | Id of the writing CPU |
| online_cnt | input | CNT_W | Number of online CPUs |
| rd_data | output | 32 | Read value of the register, always zero |
| done | output | 1 | One-cycle pulse after each write |
| hit | output | NUM_CPUS | CPUs targeted by the last write, valid while done is high |
| pend | output | NUM_CPUS*16 | Pending bits, index cpu*16+irq |
| src | output | NUM_CPUS*16*NUM_CPUS | Source masks, index (cpu*16+irq)*NUM_CPUS+sender |

## Verification
The bench builds the block with NUM_CPUS = 4. At that size it can step through every online count from 1 to 4, every requester id, all four filter codes and every 4-bit target list. The list upper nibble and the unused bits of the word are varied alongside. This covers the cases of an empty list, a requester that is offline and a list naming only absent CPUs. Across the whole sweep the full pending and source state is compared with an arithmetic model after every write.

// File: rtl/sgid_pkg.sv
package sgid_pkg;

    localparam int NUM_SGI = 16;
    localparam int SGI_W   = 4;
    localparam int LIST_W  = 8;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } filt_e;

    typedef struct packed {
        filt_e              mode;
        logic [LIST_W-1:0]  list;
        logic [SGI_W-1:0]   irq;
    } sgi_cmd_t;

    function automatic sgi_cmd_t unpack_cmd(input logic [31:0] word);
        sgi_cmd_t c;
        c.irq  = word[3:0];
        c.list = word[23:16];
        c.mode = filt_e'(word[25:24]);
        return c;
    endfunction

endpackage

// File: rtl/sgid_decode.sv
module sgid_decode
    import sgid_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int CPU_W    = 3,
    parameter int CNT_W    = 4
) (
    input  logic [31:0]         word,
    input  logic [CPU_W-1:0]    req_id,
    input  logic [CNT_W-1:0]    online_cnt,
    output logic [NUM_CPUS-1:0] targets,
    output logic [SGI_W-1:0]    irq
);

    sgi_cmd_t              cmd;
    logic [NUM_CPUS-1:0]   online_mask;
    logic [NUM_CPUS-1:0]   self_mask;

    assign cmd = unpack_cmd(word);
    assign irq = cmd.irq;

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
        assign online_mask[i] = (CNT_W'(i) < online_cnt);
        assign self_mask[i]   = (CPU_W'(i) == req_id);
    end

    always_comb begin
        unique case (cmd.mode)
            FLT_LIST:   targets = cmd.list[NUM_CPUS-1:0] & online_mask;
            FLT_OTHERS: targets = online_mask & ~self_mask;
            FLT_SELF:   targets = self_mask;
            default:    targets = '0;
        endcase
    end

endmodule

// File: rtl/sgid_bank.sv
module sgid_bank
    import sgid_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int CPU_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          upd,
    input  logic [SGI_W-1:0]              irq,
    input  logic [CPU_W-1:0]              req_id,
    output logic [NUM_SGI-1:0]            pend_o,
    output logic [NUM_SGI*NUM_CPUS-1:0]   src_o
);

    logic [NUM_SGI-1:0]                 pend_q;
    logic [NUM_SGI-1:0][NUM_CPUS-1:0]   src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            src_q  <= '0;
        end else if (upd) begin
            pend_q[irq] <= 1'b1;
            if (int'(req_id) < NUM_CPUS)
                src_q[irq][req_id] <= 1'b1;
        end
    end

    assign pend_o = pend_q;
    assign src_o  = src_q;

    // R6: pending bits are only ever added to
    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R6: an update marks the named interrupt
    a_r6_pend_mark: assert property (@(posedge clk) disable iff (rst)
        upd |=> pend_q[$past(irq)]);

    // R7: an update records the sender
    a_r7_src_mark: assert property (@(posedge clk) disable iff (rst)
        (upd && int'(req_id) < NUM_CPUS) |=> src_q[$past(irq)][$past(req_id)]);

    // R6/R7: without an update nothing moves
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(pend_q) && $stable(src_q)));

endmodule

// File: rtl/sgid_dispatch.sv
module sgid_dispatch
    import sgid_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
    localparam int CNT_W   = $clog2(NUM_CPUS + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_en,
    input  logic [31:0]                          wr_data,
    input  logic [CPU_W-1:0]                     req_id,
    input  logic [CNT_W-1:0]                     online_cnt,
    output logic [31:0]                          rd_data,
    output logic                                 done,
    output logic [NUM_CPUS-1:0]                  hit,
    output logic [NUM_CPUS*NUM_SGI-1:0]          pend,
    output logic [NUM_CPUS*NUM_SGI*NUM_CPUS-1:0] src
);

    localparam int SRC_PER_CPU = NUM_SGI * NUM_CPUS;

    logic [NUM_CPUS-1:0] targets;
    logic [SGI_W-1:0]    irq;
    logic [NUM_CPUS-1:0] hit_q;
    logic                done_q;

    sgid_decode #(
        .NUM_CPUS (NUM_CPUS),
        .CPU_W    (CPU_W),
        .CNT_W    (CNT_W)
    ) i_decode (
        .word       (wr_data),
        .req_id     (req_id),
        .online_cnt (online_cnt),
        .targets    (targets),
        .irq        (irq)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
        sgid_bank #(
            .NUM_CPUS (NUM_CPUS),
            .CPU_W    (CPU_W)
        ) i_bank (
            .clk    (clk),
            .rst    (rst),
            .upd    (wr_en & targets[c]),
            .irq    (irq),
            .req_id (req_id),
            .pend_o (pend[c*NUM_SGI +: NUM_SGI]),
            .src_o  (src[c*SRC_PER_CPU +: SRC_PER_CPU])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= '0;
            done_q <= 1'b0;
        end else begin
            hit_q  <= wr_en ? targets : '0;
            done_q <= wr_en;
        end
    end

    assign hit     = hit_q;
    assign done    = done_q;
    assign rd_data = '0;

    // R8: done follows each strobe by exactly one cycle
    a_r8_done_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> done);
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !done);
    a_r8_hit_with_done: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |-> done);

    // R5: reserved filter hits nobody
    a_r5_reserved_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[25:24] == 2'd3) |=> (hit == '0));

    // R3: the requester never targets itself with filter 1
    a_r3_no_self: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[25:24] == 2'd1 && int'(req_id) < NUM_CPUS)
            |=> !hit[$past(req_id)]);

    // R4: filter 2 hits only the requester
    a_r4_self_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[25:24] == 2'd2 && int'(req_id) < NUM_CPUS)
            |=> ($onehot0(hit) && hit[$past(req_id)]));

endmodule

// File: tb/test_sgid_dispatch.sv
module test_sgid_dispatch;

    localparam int NC    = 4;
    localparam int NS    = 16;
    localparam int CPU_W = 2;
    localparam int CNT_W = 3;
    localparam int PW    = NC * NS;
    localparam int SW    = NC * NS * NC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [CPU_W-1:0]  req_id = '0;
    logic [CNT_W-1:0]  online_cnt = 3'd1;
    logic [31:0]       rd_data;
    logic              done;
    logic [NC-1:0]     hit;
    logic [PW-1:0]     pend;
    logic [SW-1:0]     src;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [PW-1:0] exp_pend;
    logic [SW-1:0] exp_src;

    always #10 clk = ~clk;

    sgid_dispatch #(.NUM_CPUS(NC)) i_sgid_dispatch (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .req_id(req_id), .online_cnt(online_cnt), .rd_data(rd_data),
        .done(done), .hit(hit), .pend(pend), .src(src)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            finish_run();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_pend = '0;
        exp_src  = '0;
        chk(pend == '0, "R10 pend", pend, 0);
        chk(src == '0, "R10 src", src, 0);
        chk(done == 1'b0 && hit == '0, "R10 done/hit", {done, hit}, 0);
    endtask

    initial begin
        int n = 0;
        do_reset();
        for (int onl = 1; onl <= NC; onl++) begin
            for (int rq = 0; rq < NC; rq++) begin
                for (int md = 0; md < 4; md++) begin
                    for (int ls = 0; ls < 16; ls++) begin
                        logic [7:0]    lbyte;
                        logic [3:0]    irq;
                        logic [NC-1:0] omask;
                        logic [NC-1:0] tgt;
                        logic [31:0]   w;
                        if (n % 256 == 255) do_reset();
                        lbyte = {4'((n * 3) & 15), 4'(ls)};
                        irq   = 4'(n % 16);
                        omask = NC'((1 << onl) - 1);
                        // R2/R3/R4/R5 expected targets, computed arithmetically
                        case (md)
                            0: tgt = lbyte[NC-1:0] & omask;
                            1: tgt = omask & ~NC'(1 << rq);
                            2: tgt = NC'(1 << rq);
                            default: tgt = '0;
                        endcase
                        // R1: scatter junk into unused fields
                        w = {6'(n * 5), 2'(md), lbyte, 12'(n * 7), irq};
                        chk(done == 1'b0 && hit == '0, "R8 idle", {done, hit}, 0);
                        wr_en      = 1'b1;
                        wr_data    = w;
                        req_id     = CPU_W'(rq);
                        online_cnt = CNT_W'(onl);
                        @(negedge clk);
                        wr_en = 1'b0;
                        wr_data = ~w;
                        for (int c = 0; c < NC; c++) begin
                            if (tgt[c]) begin
                                exp_pend[c*NS + irq] = 1'b1;
                                exp_src[(c*NS + irq)*NC + rq] = 1'b1;
                            end
                        end
                        chk(done == 1'b1, "R8 done", done, 1);
                        case (md)
                            0: chk(hit == tgt, "R2 hit", hit, tgt);
                            1: chk(hit == tgt, "R3 hit", hit, tgt);
                            2: chk(hit == tgt, "R4 hit", hit, tgt);
                            default: chk(hit == tgt, "R5 hit", hit, tgt);
                        endcase
                        chk(pend == exp_pend, "R6 pend R1", pend, exp_pend);
                        chk(src == exp_src, "R7 src", src, exp_src);
                        chk(rd_data == '0, "R9 rd_data", rd_data, 0);
                        @(negedge clk);
                        n++;
                    end
                end
            end
        end
        chk(done == 1'b0 && hit == '0, "R8 final idle", {done, hit}, 0);
        finish_run();
    end

endmodule